// File: doc/BRIEF.md
# Double-Buffered Pulse-Width Modulator

This block drives one pulse-width-modulated output. An 8-bit period counter counts from zero up to a programmable period value and then wraps. A divide counter runs underneath it and supplies two fine bits, so the time base that the duty value is compared against is 10 bits wide. The output goes high when a period starts and goes low when the 10-bit time base reaches the active duty value. A prescale select stretches each count step by 1, 4 or 16.

The duty value is presented as an 8-bit high part and a separate 2-bit low part. It is captured into a buffer register on every clock. It is copied into the active compare register only when the counter rolls over, so a duty change never cuts a period short. A duty value of zero keeps the output low for the whole period. A duty value past the end of the period keeps the output high. Deasserting the enable clears the counters and forces the output low.

Top module: `pwm_dbuf_top`

## Requirements
- R1: After reset the output is low. With the enable low it stays low.
- R2: The prescale select encodes 0 as divide-by-1, 1 as divide-by-4, and 2 or 3 as divide-by-16 (P). One output period lasts (period_i + 1) × 4 × P input clocks.
- R3: When the counter equals period_i on a count step, the next step clears the counter, sets the output and copies the duty buffer into the active compare register. After the enable rises, the first set therefore comes (period_i + 1) × 4 × P clocks later.
- R4: For a duty value D = duty_hi_i × 4 + duty_lo_i with 0 < D < 4 × (period_i + 1), the output stays high for exactly D × P input clocks of each period. duty_lo_i supplies the two least significant bits of D.
- R5: A duty value of 0 suppresses the set at the period start, so the output stays low for the whole period.
- R6: A duty value of 4 × (period_i + 1) or more never matches the time base, so the output stays high across periods.
- R7: A duty change made during a period does not alter that period's high time. It takes effect from the next period.
- R8: Driving the enable low forces the output low on the next clock and restarts the counters. After re-enabling, the first period begins with the output low.
- R9: period_i is compared live on every count step. A new value written early in a period sets the length of that same period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run control; low forces the output low and clears the counters |
| presc_sel_i | input | 2 | Prescale select: 0 = /1, 1 = /4, 2 or 3 = /16 |
| period_i | input | 8 | Terminal value of the period counter |
| duty_hi_i | input | 8 | Upper eight bits of the duty value |
| duty_lo_i | input | 2 | Lower two bits of the duty value |
| pwm_o | output | 1 | Modulated output |

## Verification
The embedded assertions check the following on every cycle: a rollover clears the counter, loads the active duty from the buffer, and sets or suppresses the output according to whether the buffered duty is zero. Between rollovers the active duty stays unchanged, a disabled block keeps its output low and its counter at zero, and the divide counter restarts after each step. The scenarios alone can show the absolute timing: the high times and period lengths for every prescale setting, the fine bits taken from the low duty part, full-high operation above the span, a duty write landing in the following period, and a live period change.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

   // Prescale select codes; codes above the last level clamp to it.
   typedef enum logic [1:0] {
      PRE_DIV1  = 2'd0,
      PRE_DIV4  = 2'd1,
      PRE_DIV16 = 2'd2
   } pre_sel_e;

   // Clamp a select code to the highest implemented level.
   function automatic int unsigned clamp_level(input int unsigned sel, input int unsigned levels);
      return (sel >= levels) ? levels - 1 : sel;
   endfunction

endpackage

// File: rtl/pwm_dbuf_prescaler.sv
module pwm_dbuf_prescaler
   import pwm_dbuf_pkg::*;
#(
   parameter int unsigned FINE_W     = 2,
   parameter int unsigned PRE_STEP   = 2,
   parameter int unsigned PRE_LEVELS = 3,
   parameter int unsigned SEL_W      = 2,
   localparam int unsigned DIV_W     = FINE_W + PRE_STEP * (PRE_LEVELS - 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic              tick_o,
   output logic [FINE_W-1:0] fine_n_o
);

   if (PRE_LEVELS < 1 || PRE_LEVELS > (1 << SEL_W)) begin : g_bad_levels
      $error("PRE_LEVELS must be between 1 and 2**SEL_W");
   end
   if (FINE_W < 1) begin : g_bad_fine
      $error("FINE_W must be at least 1");
   end

   logic [DIV_W-1:0]  div_q, div_n;
   logic [DIV_W-1:0]  last_a [PRE_LEVELS];
   logic [FINE_W-1:0] fine_a [PRE_LEVELS];
   logic [SEL_W-1:0]  lvl;

   // One terminal count and one fine-bit slice per prescale level.
   for (genvar g = 0; g < PRE_LEVELS; g++) begin : g_lvl
      assign last_a[g] = DIV_W'((64'd1 << (FINE_W + PRE_STEP * g)) - 64'd1);
      assign fine_a[g] = FINE_W'(div_n >> (PRE_STEP * g));
   end

   always_comb lvl = SEL_W'(clamp_level(int'(sel_i), PRE_LEVELS));

   assign tick_o = en_i && (div_q >= last_a[lvl]);

   always_comb begin
      if (!en_i || tick_o) div_n = '0;
      else                 div_n = div_q + DIV_W'(1);
   end

   assign fine_n_o = fine_a[lvl];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) div_q <= '0;
      else         div_q <= div_n;
   end

   // R2: each count step restarts the divide counter
   a_r2_step_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> (div_q == '0));

endmodule

// File: rtl/pwm_dbuf_period_cnt.sv
module pwm_dbuf_period_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             roll_o,
   output logic [CNT_W-1:0] cnt_n_o
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   // The period value is compared live on every step.
   assign roll_o = tick_i && (cnt_q == period_i);

   always_comb begin
      if (!en_i || roll_o) cnt_n_o = '0;
      else if (tick_i)     cnt_n_o = cnt_q + CNT_W'(1);
      else                 cnt_n_o = cnt_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_n_o;
   end

   // R3: a rollover leaves the counter at zero
   a_r3_roll_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      roll_o |=> (cnt_q == '0));

   // R8: a disabled block holds its counter at zero
   a_r8_cnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (cnt_q == '0));

   // R9: without a step the counter holds its value
   a_r9_hold_between_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_dbuf_duty_regs.sv
module pwm_dbuf_duty_regs #(
   parameter int unsigned DUTY_W = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              roll_i,
   input  logic [DUTY_W-1:0] duty_i,
   output logic [DUTY_W-1:0] act_o,
   output logic              buf_zero_o
);

   logic [DUTY_W-1:0] buf_q;
   logic [DUTY_W-1:0] act_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         buf_q <= '0;
         act_q <= '0;
      end else begin
         buf_q <= duty_i;
         if (roll_i) act_q <= buf_q;
      end
   end

   assign act_o      = act_q;
   assign buf_zero_o = (buf_q == '0);

   // R3: the buffered value reaches the compare register at rollover
   a_r3_duty_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      roll_i |=> (act_q == $past(buf_q)));

   // R7: the active duty is frozen between rollovers
   a_r7_duty_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !roll_i |=> $stable(act_q));

endmodule

// File: rtl/pwm_dbuf_out_stage.sv
module pwm_dbuf_out_stage #(
   parameter int unsigned TB_W = 10
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            en_i,
   input  logic            roll_i,
   input  logic            buf_zero_i,
   input  logic [TB_W-1:0] tb_n_i,
   input  logic [TB_W-1:0] act_i,
   output logic            pwm_o
);

   logic out_q, out_n;

   always_comb begin
      out_n = out_q;
      if (!en_i)                out_n = 1'b0;
      else if (roll_i)          out_n = !buf_zero_i;
      else if (tb_n_i == act_i) out_n = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) out_q <= 1'b0;
      else         out_q <= out_n;
   end

   assign pwm_o = out_q;

   // R3: a rollover with a nonzero duty raises the output
   a_r3_set_on_roll: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && roll_i && !buf_zero_i) |=> out_q);

   // R5: a zero duty keeps the output low at the period start
   a_r5_zero_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && roll_i && buf_zero_i) |=> !out_q);

   // R8: disabling forces the output low
   a_r8_disable_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !out_q);

endmodule

// File: rtl/pwm_dbuf_top.sv
module pwm_dbuf_top #(
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned FINE_W     = 2,
   parameter int unsigned PRE_STEP   = 2,
   parameter int unsigned PRE_LEVELS = 3,
   parameter int unsigned SEL_W      = 2,
   localparam int unsigned TB_W      = CNT_W + FINE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              enable_i,
   input  logic [SEL_W-1:0]  presc_sel_i,
   input  logic [CNT_W-1:0]  period_i,
   input  logic [CNT_W-1:0]  duty_hi_i,
   input  logic [FINE_W-1:0] duty_lo_i,
   output logic              pwm_o
);

   logic              tick, roll, buf_zero;
   logic [FINE_W-1:0] fine_n;
   logic [CNT_W-1:0]  cnt_n;
   logic [TB_W-1:0]   act, tb_n;

   pwm_dbuf_prescaler #(
      .FINE_W(FINE_W), .PRE_STEP(PRE_STEP), .PRE_LEVELS(PRE_LEVELS), .SEL_W(SEL_W)
   ) u_pre (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(enable_i), .sel_i(presc_sel_i),
      .tick_o(tick), .fine_n_o(fine_n)
   );

   pwm_dbuf_period_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(enable_i), .tick_i(tick),
      .period_i(period_i), .roll_o(roll), .cnt_n_o(cnt_n)
   );

   pwm_dbuf_duty_regs #(.DUTY_W(TB_W)) u_duty (
      .clk_i(clk_i), .rst_ni(rst_ni), .roll_i(roll),
      .duty_i({duty_hi_i, duty_lo_i}), .act_o(act), .buf_zero_o(buf_zero)
   );

   // Time base of the coming cycle: counter above, fine bits below.
   assign tb_n = {cnt_n, fine_n};

   pwm_dbuf_out_stage #(.TB_W(TB_W)) u_out (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(enable_i), .roll_i(roll),
      .buf_zero_i(buf_zero), .tb_n_i(tb_n), .act_i(act), .pwm_o(pwm_o)
   );

endmodule

// File: tb/pwm_dbuf_top_tb_top.sv
`timescale 1ns/1ps
module pwm_dbuf_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [1:0] presc_sel = 2'd0;
   logic [7:0] period = 8'd0;
   logic [7:0] duty_hi = 8'd0;
   logic [1:0] duty_lo = 2'd0;
   logic       pwm;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2 clk = ~clk;   // 250 MHz

   pwm_dbuf_top dut_i (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .presc_sel_i(presc_sel),
      .period_i(period), .duty_hi_i(duty_hi), .duty_lo_i(duty_lo), .pwm_o(pwm)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_duty(input int d);
      duty_hi = 8'(d >> 2);
      duty_lo = 2'(d);
   endtask

   // Count edges until the output shows val; -1 on timeout.
   task automatic wait_level(input logic val, output int n);
      n = 0;
      for (int i = 0; i < 5000; i++) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (pwm === val) return;
      end
      n = -1;
   endtask

   task automatic count_level(input logic val, input int cycles, output int n);
      n = 0;
      for (int i = 0; i < cycles; i++) begin
         tick();
         if (pwm === val) n++;
      end
   endtask

   task automatic setup(input int sel, input int pr, input int d, output int first);
      enable = 1'b0;
      tick();
      tick();
      presc_sel = 2'(sel);
      period = 8'(pr);
      set_duty(d);
      tick();
      enable = 1'b1;
      wait_level(1'b1, first);
   endtask

   task automatic t_reset();
      int highs;
      @(negedge clk);
      chk(pwm === 1'b0, "R1 output in reset", int'(pwm), 0);
      rst_n = 1'b1;
      count_level(1'b1, 20, highs);
      chk(highs == 0, "R1 idle output after reset", highs, 0);
   endtask

   task automatic t_first_period();
      int first, h, l;
      setup(0, 10, 20, first);
      chk(first == 44, "R3 first set after enable", first, 44);
      wait_level(1'b0, h);
      chk(h == 20, "R4 high time div1", h, 20);
      wait_level(1'b1, l);
      chk(h + l == 44, "R2 period div1", h + l, 44);
   endtask

   task automatic t_prescale();
      int first, h, l;
      setup(1, 7, 14, first);
      chk(first == 128, "R2 first period div4", first, 128);
      wait_level(1'b0, h);
      chk(h == 56, "R4 high time div4", h, 56);
      wait_level(1'b1, l);
      chk(h + l == 128, "R2 period div4", h + l, 128);
      setup(2, 3, 5, first);
      chk(first == 256, "R2 first period div16", first, 256);
      wait_level(1'b0, h);
      chk(h == 80, "R4 high time div16", h, 80);
      setup(3, 3, 5, first);
      chk(first == 256, "R2 select 3 clamps to div16", first, 256);
   endtask

   task automatic t_fine_bits();
      int first, h;
      setup(0, 255, 1000, first);
      chk(first == 1024, "R2 full counter span", first, 1024);
      wait_level(1'b0, h);
      chk(h == 1000, "R4 wide duty", h, 1000);
      setup(0, 2, 3, first);
      wait_level(1'b0, h);
      chk(h == 3, "R4 low bits only", h, 3);
   endtask

   task automatic t_zero_duty();
      int highs;
      enable = 1'b0;
      tick();
      presc_sel = 2'd0;
      period = 8'd10;
      set_duty(0);
      tick();
      enable = 1'b1;
      count_level(1'b1, 200, highs);
      chk(highs == 0, "R5 zero duty stays low", highs, 0);
   endtask

   task automatic t_full_duty();
      int first, lows;
      setup(0, 10, 44, first);
      count_level(1'b0, 150, lows);
      chk(lows == 0, "R6 duty equal to span", lows, 0);
      setup(0, 10, 1023, first);
      count_level(1'b0, 150, lows);
      chk(lows == 0, "R6 duty above span", lows, 0);
   endtask

   task automatic t_mid_write();
      int first, h, l, h2;
      setup(0, 9, 12, first);
      set_duty(30);
      wait_level(1'b0, h);
      chk(h == 12, "R7 current period keeps old duty", h, 12);
      wait_level(1'b1, l);
      wait_level(1'b0, h2);
      chk(h2 == 30, "R7 next period uses new duty", h2, 30);
   endtask

   task automatic t_live_period();
      int first, h, l;
      setup(0, 5, 8, first);
      chk(first == 24, "R9 initial period", first, 24);
      period = 8'd12;
      wait_level(1'b0, h);
      wait_level(1'b1, l);
      chk(h + l == 52, "R9 period changed mid run", h + l, 52);
   endtask

   task automatic t_disable();
      int first, highs;
      setup(0, 10, 30, first);
      tick();
      tick();
      enable = 1'b0;
      tick();
      chk(pwm === 1'b0, "R8 output low after disable", int'(pwm), 0);
      count_level(1'b1, 20, highs);
      chk(highs == 0, "R8 stays low while disabled", highs, 0);
      enable = 1'b1;
      wait_level(1'b1, first);
      chk(first == 44, "R8 restart begins low", first, 44);
   endtask

   initial begin
      t_reset();
      t_first_period();
      t_prescale();
      t_fine_bits();
      t_zero_duty();
      t_full_duty();
      t_mid_write();
      t_live_period();
      t_disable();
      summary();
      $finish;
   end

endmodule